// File: doc/BRIEF.md
# Downlink Serial Frame Receiver with Idle-Pattern Lock

This block sits at the end of a one-wire serial downlink. It shifts the line in one bit per clock and finds where each 16-bit frame starts by hunting for the idle pattern. Once it has seen enough idle frames in a row at one bit offset, it declares lock. From then on it turns every frame into two symbol values. Each 8-bit symbol is a balanced code word, four ones and four zeros.

Two kinds of traffic are carried. A trigger frame holds a bunch-reset bit, a four-bit map of accept bits and a seven-bit tag. The receiver expands it into accept pulses on four consecutive bunch crossings, one crossing being four bit-clocks. A command is framed by a start frame that carries a chip address and an end frame. Between them, seven data frames each carry a 7-bit chunk. The chunks are concatenated into a 49-bit word, which is delivered only when the address matches this chip or is the broadcast address. Trigger frames may be interleaved with the chunks of a command.

Top module: `dlink_rx`

## Requirements
- R1: During and directly after reset, lock_o, l0a_o, bcr_o, xing_o, cmd_valid_o and cmd_err_o are 0, and tag_o and cmd_word_o are all zeros.
- R2: lock_o rises in the clock after the last bit of the 16th consecutive idle frame found at one bit offset, and stays 0 after only 15. Frames arrive most significant bit first, and the idle frame is 16'hD8E1.
- R3: A symbol byte is legal when it has exactly four ones. Its value is its rank among all such bytes sorted in increasing numeric order (0x0F is 0, 0xF0 is 69). Values 0-63 are data. 64 and 65 form the idle frame, 66 opens a command, 67 closes a command, 68 is the end marker, and 69 is illegal.
- R4: A data frame outside a command is a trigger. Its first value is {bcr, map[3:0], tag[6]} and its second value is tag[5:0]. One clock after the frame ends, l0a_o carries map[3] for four clocks, then map[2], map[1] and map[0] for four clocks each. bcr_o is high only in the first crossing. xing_o marks the first clock of each crossing, and tag_o shows the tag from that point on.
- R5: A command is a start frame {66, id}, then seven data frames whose first value has bits [5:1] zero, each giving the chunk {first[0], second[5:0]}, then the end frame {67, 68}. The first chunk becomes bits 48:42 of cmd_word_o. cmd_valid_o pulses for one clock, one clock after the end frame.
- R6: A command whose id is neither chip_id_i nor 5'b11111 produces no cmd_valid_o and no cmd_err_o. Id 5'b11111 is accepted by every chip.
- R7: An end frame after a chunk count other than seven, or an undecodable frame inside a command, produces a one-clock cmd_err_o pulse and no cmd_valid_o.
- R8: Inside a command, a data frame whose first value has bit 5 or any of bits 4:1 set is handled as a trigger and does not count as a chunk.
- R9: While locked, four consecutive undecodable frames clear lock_o one clock after the fourth one. Three undecodable frames followed by a decodable frame leave lock_o at 1.
- R10: While lock_o is 0, no l0a_o, bcr_o or cmd_valid_o pulse is produced for any frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| sdi_i | input | 1 | Serial downlink data |
| chip_id_i | input | 5 | Address of this chip |
| lock_o | output | 1 | Frame alignment found |
| xing_o | output | 1 | First clock of a bunch crossing |
| l0a_o | output | 1 | Accept pulse for the current crossing |
| bcr_o | output | 1 | Bunch-counter reset for the current crossing |
| tag_o | output | 7 | Tag of the latest trigger frame |
| cmd_word_o | output | 49 | Last delivered command word |
| cmd_valid_o | output | 1 | One-clock strobe for a delivered command |
| cmd_err_o | output | 1 | One-clock strobe for an aborted command |

## Verification
The hardest case to reach is the lock state machine at its edges. Lock must not rise after 15 idles but must rise after 16. It must survive runs of three bad frames and fall on the fourth. The stimulus first puts three stray bits ahead of the idle stream, so the receiver has to realign at an offset that is not a frame boundary. It then checks lock_o frame by frame, and later drives bursts of all-zero frames that break up the traffic. A trigger placed between command chunks shows that it is not counted as a chunk, because the command that contains it still delivers the expected word.

// File: rtl/dlink_pkg.sv
package dlink_pkg;
  localparam int SYM_W    = 8;
  localparam int FRAME_W  = 2 * SYM_W;
  localparam int VAL_W    = 6;
  localparam int IDX_W    = 7;
  localparam int MAP_W    = 4;
  localparam int XING_BITS = FRAME_W / MAP_W;
  localparam int TAG_W    = VAL_W + 1;
  localparam int ID_W     = 5;
  localparam int SYM_ONES = SYM_W / 2;

  localparam logic [IDX_W-1:0] IDX_IDLE_A = 7'd64;
  localparam logic [IDX_W-1:0] IDX_IDLE_B = 7'd65;
  localparam logic [IDX_W-1:0] IDX_OPEN   = 7'd66;
  localparam logic [IDX_W-1:0] IDX_CLOSE  = 7'd67;
  localparam logic [IDX_W-1:0] IDX_MARK   = 7'd68;

  localparam logic [FRAME_W-1:0] IDLE_WORD = 16'hD8E1;

  typedef enum logic [2:0] {
    FK_BAD, FK_IDLE, FK_OPEN, FK_CLOSE, FK_DATA
  } frame_kind_t;

  // n choose k for small arguments
  function automatic int unsigned choose(input int unsigned n, input int unsigned k);
    int unsigned r;
    r = 1;
    if (k > n) return 0;
    for (int i = 0; i < SYM_W; i++)
      if (i < int'(k)) r = r * (n - i) / (i + 1);
    return r;
  endfunction

  // rank of a weight-balanced byte among all balanced bytes, ascending
  function automatic logic [IDX_W-1:0] sym_rank(input logic [SYM_W-1:0] b);
    int unsigned r;
    int unsigned seen;
    r = 0;
    seen = 0;
    for (int p = 0; p < SYM_W; p++) begin
      if (b[p]) begin
        seen = seen + 1;
        r = r + choose(p, seen);
      end
    end
    return r[IDX_W-1:0];
  endfunction

  function automatic logic sym_legal(input logic [SYM_W-1:0] b);
    return ($countones(b) == SYM_ONES) && (sym_rank(b) <= IDX_MARK);
  endfunction
endpackage

// File: rtl/dlink_align.sv
module dlink_align
  import dlink_pkg::*;
#(
  parameter int LOCK_IDLES = 16,
  parameter int DROP_BAD   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sdi_i,
  input  logic               bad_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               frame_vld_o,
  output logic               locked_o,
  output logic               idle_hit_o
);
  localparam int POS_W = $clog2(FRAME_W);
  localparam int RUN_W = $clog2(LOCK_IDLES + 1);
  localparam int BAD_W = $clog2(DROP_BAD + 1);

  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] window;
  logic [POS_W-1:0]   pos;
  logic [RUN_W-1:0]   run;
  logic [BAD_W-1:0]   badc;
  logic               at_end;
  logic               realign;

  assign window     = {shreg[FRAME_W-2:0], sdi_i};
  assign at_end     = (pos == POS_W'(FRAME_W - 1));
  assign idle_hit_o = (window == IDLE_WORD);
  assign realign    = !locked_o && idle_hit_o && !at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg       <= '0;
      frame_o     <= '0;
      frame_vld_o <= 1'b0;
      pos         <= '0;
      run         <= '0;
      badc        <= '0;
      locked_o    <= 1'b0;
    end else begin
      shreg       <= window;
      frame_vld_o <= 1'b0;
      if (at_end || realign) begin
        pos         <= '0;
        frame_vld_o <= 1'b1;
        frame_o     <= window;
      end else begin
        pos <= pos + 1'b1;
      end

      if (!locked_o) begin
        badc <= '0;
        if (realign) begin
          run <= RUN_W'(1);
        end else if (at_end) begin
          if (!idle_hit_o) begin
            run <= '0;
          end else if (run == RUN_W'(LOCK_IDLES - 1)) begin
            run      <= '0;
            locked_o <= 1'b1;
          end else begin
            run <= run + 1'b1;
          end
        end
      end else if (bad_i) begin
        if (badc == BAD_W'(DROP_BAD - 1)) begin
          badc     <= '0;
          locked_o <= 1'b0;
        end else begin
          badc <= badc + 1'b1;
        end
      end else if (frame_vld_o) begin
        badc <= '0;
      end
    end
  end
endmodule

// File: rtl/dlink_symdec.sv
module dlink_symdec
  import dlink_pkg::*;
(
  input  logic [FRAME_W-1:0] frame_i,
  output frame_kind_t        kind_o,
  output logic [VAL_W-1:0]   v0_o,
  output logic [VAL_W-1:0]   v1_o
);
  logic [IDX_W-1:0] idx [2];
  logic [1:0]       legal;

  for (genvar s = 0; s < 2; s++) begin : g_sym
    logic [SYM_W-1:0] byte_s;
    assign byte_s   = frame_i[FRAME_W-1-s*SYM_W -: SYM_W];
    assign idx[s]   = sym_rank(byte_s);
    assign legal[s] = sym_legal(byte_s);
  end

  assign v0_o = idx[0][VAL_W-1:0];
  assign v1_o = idx[1][VAL_W-1:0];

  always_comb begin
    kind_o = FK_BAD;
    if (&legal) begin
      if (idx[0] == IDX_IDLE_A && idx[1] == IDX_IDLE_B)
        kind_o = FK_IDLE;
      else if (idx[0] == IDX_OPEN && idx[1] < IDX_W'(2 ** ID_W))
        kind_o = FK_OPEN;
      else if (idx[0] == IDX_CLOSE && idx[1] == IDX_MARK)
        kind_o = FK_CLOSE;
      else if (!idx[0][VAL_W] && !idx[1][VAL_W])
        kind_o = FK_DATA;
    end
  end
endmodule

// File: rtl/dlink_trig.sv
module dlink_trig
  import dlink_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_vld_i,
  input  logic             hit_i,
  input  logic [VAL_W-1:0] v0_i,
  input  logic [VAL_W-1:0] v1_i,
  output logic             l0a_o,
  output logic             bcr_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             xing_o
);
  localparam int CNT_W = $clog2(XING_BITS);

  logic [MAP_W-1:0] map_sr;
  logic [CNT_W-1:0] sub;
  logic             xing_end;

  assign xing_end = (sub == CNT_W'(XING_BITS - 1));
  assign l0a_o    = map_sr[MAP_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_sr <= '0;
      bcr_o  <= 1'b0;
      tag_o  <= '0;
      sub    <= '0;
      xing_o <= 1'b0;
    end else begin
      xing_o <= 1'b0;
      if (frame_vld_i) begin
        map_sr <= hit_i ? v0_i[MAP_W:1] : '0;
        bcr_o  <= hit_i & v0_i[VAL_W-1];
        if (hit_i) tag_o <= {v0_i[0], v1_i};
        sub    <= '0;
        xing_o <= 1'b1;
      end else if (xing_end) begin
        map_sr <= {map_sr[MAP_W-2:0], 1'b0};
        bcr_o  <= 1'b0;
        sub    <= '0;
        xing_o <= 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dlink_cmd.sv
module dlink_cmd
  import dlink_pkg::*;
#(
  parameter int CHUNKS = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          locked_i,
  input  logic                          frame_vld_i,
  input  frame_kind_t                   kind_i,
  input  logic [VAL_W-1:0]              v0_i,
  input  logic [VAL_W-1:0]              v1_i,
  input  logic [ID_W-1:0]               chip_id_i,
  output logic                          busy_o,
  output logic [CHUNKS*(VAL_W+1)-1:0]   word_o,
  output logic                          valid_o,
  output logic                          err_o
);
  localparam int CHUNK_W = VAL_W + 1;
  localparam int WORD_W  = CHUNKS * CHUNK_W;
  localparam int CNT_W   = $clog2(CHUNKS + 1);

  logic [WORD_W-1:0]  acc;
  logic [CNT_W-1:0]   cnt;
  logic               match;
  logic               is_chunk;
  logic               full;
  logic [ID_W-1:0]    rx_id;

  assign is_chunk = (v0_i[VAL_W-1:1] == '0);
  assign full     = (cnt == CNT_W'(CHUNKS));
  assign rx_id    = v1_i[ID_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      cnt     <= '0;
      match   <= 1'b0;
      busy_o  <= 1'b0;
      word_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      if (!locked_i) begin
        busy_o <= 1'b0;
      end else if (frame_vld_i) begin
        unique case (kind_i)
          FK_OPEN: begin
            err_o  <= busy_o;
            busy_o <= 1'b1;
            cnt    <= '0;
            match  <= (rx_id == chip_id_i) || (&rx_id);
          end
          FK_DATA: begin
            if (busy_o && is_chunk) begin
              if (full) begin
                busy_o <= 1'b0;
                err_o  <= 1'b1;
              end else begin
                acc <= {acc[WORD_W-CHUNK_W-1:0], v0_i[0], v1_i};
                cnt <= cnt + 1'b1;
              end
            end
          end
          FK_CLOSE: begin
            if (busy_o) begin
              busy_o <= 1'b0;
              if (full) begin
                valid_o <= match;
                if (match) word_o <= acc;
              end else begin
                err_o <= 1'b1;
              end
            end
          end
          FK_BAD: begin
            if (busy_o) begin
              busy_o <= 1'b0;
              err_o  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dlink_rx.sv
module dlink_rx
  import dlink_pkg::*;
#(
  parameter int LOCK_IDLES = 16,
  parameter int DROP_BAD   = 4,
  parameter int CHUNKS     = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sdi_i,
  input  logic [4:0]                  chip_id_i,
  output logic                        lock_o,
  output logic                        xing_o,
  output logic                        l0a_o,
  output logic                        bcr_o,
  output logic [6:0]                  tag_o,
  output logic [CHUNKS*7-1:0]         cmd_word_o,
  output logic                        cmd_valid_o,
  output logic                        cmd_err_o
);
  logic [FRAME_W-1:0] frame;
  logic               frame_vld;
  logic               idle_hit;
  logic               bad_frame;
  logic               trig_hit;
  logic               cmd_busy;
  frame_kind_t        kind;
  logic [VAL_W-1:0]   v0;
  logic [VAL_W-1:0]   v1;

  assign bad_frame = frame_vld && lock_o && (kind == FK_BAD);
  assign trig_hit  = lock_o && (kind == FK_DATA) &&
                     ((v0[VAL_W-1:1] != '0) || !cmd_busy);

  dlink_align #(.LOCK_IDLES(LOCK_IDLES), .DROP_BAD(DROP_BAD)) u_align (
    .clk(clk), .rst_n(rst_n), .sdi_i(sdi_i), .bad_i(bad_frame),
    .frame_o(frame), .frame_vld_o(frame_vld), .locked_o(lock_o),
    .idle_hit_o(idle_hit)
  );

  dlink_symdec u_dec (
    .frame_i(frame), .kind_o(kind), .v0_o(v0), .v1_o(v1)
  );

  dlink_trig u_trig (
    .clk(clk), .rst_n(rst_n), .frame_vld_i(frame_vld), .hit_i(trig_hit),
    .v0_i(v0), .v1_i(v1), .l0a_o(l0a_o), .bcr_o(bcr_o), .tag_o(tag_o),
    .xing_o(xing_o)
  );

  dlink_cmd #(.CHUNKS(CHUNKS)) u_cmd (
    .clk(clk), .rst_n(rst_n), .locked_i(lock_o), .frame_vld_i(frame_vld),
    .kind_i(kind), .v0_i(v0), .v1_i(v1), .chip_id_i(chip_id_i),
    .busy_o(cmd_busy), .word_o(cmd_word_o), .valid_o(cmd_valid_o),
    .err_o(cmd_err_o)
  );
endmodule

// File: rtl/dlink_rx_chk.sv
module dlink_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic lock,
  input logic xing,
  input logic l0a,
  input logic bcr,
  input logic cmd_valid,
  input logic cmd_err,
  input logic frame_vld,
  input logic bad
);
  a_r7_valid_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_err));

  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r5_valid_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(frame_vld));

  a_r10_l0a_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (l0a || bcr) |-> lock);

  a_r4_l0a_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !xing |-> $stable(l0a));

  a_r2_lock_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> frame_vld);

  a_r9_drop_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(bad));
endmodule

bind dlink_rx dlink_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lock(lock_o), .xing(xing_o), .l0a(l0a_o),
  .bcr(bcr_o), .cmd_valid(cmd_valid_o), .cmd_err(cmd_err_o),
  .frame_vld(frame_vld), .bad(bad_frame)
);

// File: tb/dlink_rx_bench.sv
module dlink_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdi = 1'b0;
  logic [4:0]  chip_id = 5'b10001;
  logic        lock, xing, l0a, bcr, cmd_valid, cmd_err;
  logic [6:0]  tag;
  logic [48:0] cmd_word;

  int n_cmp = 0;
  int n_bad = 0;
  int pulses_seen = 0;
  int cmds_seen = 0;
  int errs_seen = 0;

  logic [7:0]  code [70];
  logic [8:0]  trig_q [$];   // {l0a, bcr, tag}
  logic [49:0] cmd_q  [$];   // {is_err, word}

  always #2.5 clk = ~clk;

  dlink_rx u_dlink_rx (
    .clk(clk), .rst_n(rst_n), .sdi_i(sdi), .chip_id_i(chip_id),
    .lock_o(lock), .xing_o(xing), .l0a_o(l0a), .bcr_o(bcr), .tag_o(tag),
    .cmd_word_o(cmd_word), .cmd_valid_o(cmd_valid), .cmd_err_o(cmd_err)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares design events against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (xing && (l0a || bcr)) begin
        pulses_seen++;
        if (trig_q.size() == 0) check(1'b0, "R4/R10 unexpected pulse", {l0a, bcr, tag}, 0);
        else begin
          logic [8:0] e;
          e = trig_q.pop_front();
          check({l0a, bcr, tag} == e, "R4 trigger crossing", {l0a, bcr, tag}, e);
        end
      end
      if (cmd_valid || cmd_err) begin
        if (cmd_valid) cmds_seen++;
        if (cmd_err) errs_seen++;
        if (cmd_q.size() == 0) check(1'b0, "R6/R7 unexpected command event", {cmd_err, cmd_word}, 0);
        else begin
          logic [49:0] e;
          e = cmd_q.pop_front();
          if (e[49]) check(cmd_err && !cmd_valid, "R7 error strobe", {cmd_valid, cmd_err}, 2'b01);
          else check(cmd_valid && cmd_word == e[48:0], "R5 command word", {cmd_valid, cmd_word}, {1'b1, e[48:0]});
        end
      end
    end
  end

  task automatic send_frame(input logic [15:0] f);
    for (int i = 15; i >= 0; i--) begin
      sdi = f[i];
      @(negedge clk);
    end
  endtask

  task automatic send_idle(input int n);
    for (int i = 0; i < n; i++) send_frame({code[64], code[65]});
  endtask

  // driver: sends a trigger frame and, if it should show, queues its crossings
  task automatic send_trig(input logic [3:0] map, input logic b, input logic [6:0] t,
                           input logic expect_out);
    if (expect_out)
      for (int k = 0; k < 4; k++)
        if (map[3-k] || (k == 0 && b))
          trig_q.push_back({map[3-k], (k == 0) && b, t});
    send_frame({code[{b, map, t[6]}], code[t[5:0]]});
  endtask

  task automatic send_open(input logic [4:0] id);
    send_frame({code[66], code[{1'b0, id}]});
  endtask

  task automatic send_chunk(input logic [48:0] w, input int k);
    logic [6:0] c;
    c = w[48-7*k -: 7];
    send_frame({code[{5'b0, c[6]}], code[c[5:0]]});
  endtask

  task automatic send_close();
    send_frame({code[67], code[68]});
  endtask

  task automatic send_cmd(input logic [4:0] id, input logic [48:0] w, input int nch);
    send_open(id);
    for (int k = 0; k < nch; k++) send_chunk(w, k);
    send_close();
    send_idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    int p0, c0, e0;
    n = 0;
    for (int b = 0; b < 256; b++)
      if ($countones(b[7:0]) == 4) begin
        code[n] = b[7:0];
        n++;
      end
    check(code[64] == 8'hD8 && code[65] == 8'hE1, "R3 idle code", {code[64], code[65]}, 16'hD8E1);

    repeat (4) @(negedge clk);
    check(!lock && !l0a && !bcr && !xing && !cmd_valid && !cmd_err && tag == 0 && cmd_word == 0,
          "R1 reset state", {lock, l0a, bcr, cmd_valid, cmd_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!lock && !l0a && !cmd_valid && tag == 0, "R1 after reset", {lock, l0a, tag}, 0);

    // R2: stray bits, then idles at an odd offset
    sdi = 1'b0;
    repeat (3) @(negedge clk);
    send_idle(15);
    check(lock == 1'b0, "R2 no lock after 15 idles", lock, 0);
    send_idle(1);
    check(lock == 1'b1, "R2 lock after 16 idles", lock, 1);
    send_idle(2);

    // R4: trigger patterns
    send_trig(4'b0010, 1'b0, 7'd10, 1'b1); send_idle(2);
    send_trig(4'b1010, 1'b0, 7'd22, 1'b1); send_idle(1);
    send_trig(4'b0101, 1'b0, 7'd99, 1'b1);
    send_trig(4'b1111, 1'b0, 7'd127, 1'b1); send_idle(1);
    send_trig(4'b0000, 1'b1, 7'd64, 1'b1); send_idle(1);
    send_trig(4'b0111, 1'b1, 7'd5, 1'b1); send_idle(2);
    check(trig_q.size() == 0, "R4 all trigger crossings seen", trig_q.size(), 0);

    // R5: addressed command; R6 broadcast and foreign id
    cmd_q.push_back({1'b0, 49'h081840A18388});
    send_cmd(5'b10001, 49'h081840A18388, 7);
    cmd_q.push_back({1'b0, 49'h1C7973E9D7B77});
    send_cmd(5'b11111, 49'h1C7973E9D7B77, 7);
    check(cmd_word == 49'h1C7973E9D7B77, "R6 broadcast accepted", cmd_word, 49'h1C7973E9D7B77);
    c0 = cmds_seen; e0 = errs_seen;
    send_cmd(5'b00001, 49'h123456789ABCD, 7);
    send_idle(1);
    check(cmds_seen == c0 && errs_seen == e0, "R6 foreign id ignored", cmds_seen - c0, 0);
    check(cmd_word == 49'h1C7973E9D7B77, "R6 word kept", cmd_word, 49'h1C7973E9D7B77);

    // R8: trigger inside a command
    cmd_q.push_back({1'b0, 49'h123456789ABCD});
    send_open(5'b10001);
    for (int k = 0; k < 3; k++) send_chunk(49'h123456789ABCD, k);
    send_trig(4'b1001, 1'b0, 7'd77, 1'b1);
    send_trig(4'b0000, 1'b1, 7'd3, 1'b1);
    for (int k = 3; k < 7; k++) send_chunk(49'h123456789ABCD, k);
    send_close();
    send_idle(2);
    check(cmd_word == 49'h123456789ABCD, "R8 chunks unaffected by trigger", cmd_word, 49'h123456789ABCD);

    // R7: short command, undecodable frame inside a command
    cmd_q.push_back({1'b1, 49'h0});
    send_cmd(5'b10001, 49'h0AAAAAAAAAAAA, 6);
    cmd_q.push_back({1'b1, 49'h0});
    send_open(5'b10001);
    send_chunk(49'h0AAAAAAAAAAAA, 0);
    send_frame(16'h0000);
    send_idle(2);
    check(cmd_q.size() == 0 && lock, "R7 errors reported, lock kept", cmd_q.size(), 0);

    // R9: three bad frames keep lock, four drop it
    send_frame(16'h0000); send_frame(16'h0000); send_frame(16'h0000);
    send_idle(1);
    send_frame(16'h0000); send_frame(16'h0000); send_frame(16'h0000);
    send_idle(1);
    check(lock == 1'b1, "R9 three bad frames keep lock", lock, 1);
    repeat (4) send_frame(16'h0000);
    send_idle(1);
    check(lock == 1'b0, "R9 four bad frames drop lock", lock, 0);

    // R10: nothing comes out while unlocked
    p0 = pulses_seen; c0 = cmds_seen;
    send_trig(4'b1111, 1'b1, 7'd9, 1'b0);
    send_trig(4'b1000, 1'b0, 7'd1, 1'b0);
    send_cmd(5'b10001, 49'h0F0F0F0F0F0F, 7);
    send_idle(1);
    check(pulses_seen == p0 && cmds_seen == c0, "R10 silent while unlocked", pulses_seen - p0, 0);

    // relock and confirm the path works again
    send_idle(16);
    check(lock == 1'b1, "R2 relock after 16 idles", lock, 1);
    send_trig(4'b0100, 1'b0, 7'd44, 1'b1);
    send_idle(2);
    check(trig_q.size() == 0 && cmd_q.size() == 0, "R4 scoreboard drained", trig_q.size() + cmd_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule